// File: doc/BRIEF.md
# Row-Column Decoupled Switch Allocator

This block decides, every cycle, which buffered flits of a mesh router may cross the switch and which are handed straight to the local node. The 5x5 crossbar is replaced by two 2x2 crossbars. The row crossbar drives the east and west outputs, and the column crossbar drives the north and south outputs. The block serves two input ports, and each port holds `NUM_VC` virtual channels. Each channel presents a request together with a route that the previous pipeline stage has already worked out. The route sends the flit to one crossbar, or marks it for the local node.

Flits for the local node are ejected in the same cycle. They never enter switch allocation or the crossbar, so they skip the two stages that switched flits spend in the pipeline. For each crossbar, each port offers one candidate channel, chosen by a round-robin arbiter. A single two-way round-robin arbiter then picks a winning port, and that port takes the output it asked for. The other port receives the complementary output only when its candidate wants exactly that output. Otherwise the complementary output stays idle. Switch grants leave the block one cycle after the request, and the crossbar selects follow one cycle later.

Top module: `roco_sw_alloc`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `sa_gnt_o`, `xbar_vld_o` and `xbar_src_o` are all zero, and every arbiter pointer starts at index 0.
- R2: Route code 0 means east and 1 means west, and both use the row crossbar. Code 2 means north and 3 means south, and both use the column crossbar. Code 4 means local ejection. Codes 5 to 7 are ignored: such a channel gets no grant of any kind.
- R3: A requesting channel with route 4 can receive `eject_gnt_o` in the same cycle as its request. At most one channel per port is ejected per cycle. The choice is round-robin, and the pointer moves to the channel after the winner.
- R4: For each crossbar, each port nominates at most one channel by round-robin. That port's pointer moves past the channel only when the channel wins a crossbar output. Otherwise the pointer holds.
- R5: For each crossbar, one two-way arbiter picks a winning port among the ports that have a candidate. Port 0 has priority after reset. After every grant, priority passes to the other port, and it holds in cycles with no candidates. The winner receives the output its candidate requested.
- R6: The losing port receives the complementary output of that crossbar only if its candidate requests that output. If not, that output stays idle for the cycle.
- R7: A port can win one row output and one column output in the same cycle. It never wins two outputs of the same crossbar. Two active outputs of one crossbar always name different source ports.
- R8: `sa_gnt_o` shows, one cycle after the request cycle, the channels that won a crossbar output. Bits `[p][v]` belong to port p and channel v.
- R9: `xbar_vld_o[o]` and `xbar_src_o[o]` show the switch setting two cycles after the request cycle. The output index o is 0 for east, 1 for west, 2 for north and 3 for south. The source value is the winning port number.
- R10: A channel being ejected takes no crossbar output and has no effect on crossbar arbitration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vc_req_i | input | 2*NUM_VC | Per-port, per-channel request |
| vc_route_i | input | 2*NUM_VC*3 | Precomputed route code for each channel |
| eject_gnt_o | output | 2*NUM_VC | Same-cycle ejection grant to the local node |
| sa_gnt_o | output | 2*NUM_VC | Registered switch grant per channel |
| xbar_vld_o | output | 4 | Output active: east, west, north, south |
| xbar_src_o | output | 4 | Source port for each active output |

## Verification
Each result has its own due cycle. Ejection grants are due in the request cycle itself, switch grants one clock later, and crossbar selects two clocks later. The bench drives each cycle's inputs on the falling edge and samples 3 ns later, before the next rising edge. At that point it compares the ejection grant with the model's result for the current cycle. It compares the switch grant with the result held from one cycle back, and the selects with the result held from two cycles back, shifting these expectations through a two-deep pipeline. Directed cases start from a fresh reset, so the expected values written out for round-robin order, mirroring and idle outputs depend on known pointer positions.

// File: rtl/roco_alloc_pkg.sv
package roco_alloc_pkg;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned NUM_DIMS  = 2;
  localparam int unsigned NUM_OUTS  = NUM_DIMS * 2;

  typedef enum logic [2:0] {
    RT_XPOS  = 3'd0,
    RT_XNEG  = 3'd1,
    RT_YPOS  = 3'd2,
    RT_YNEG  = 3'd3,
    RT_EJECT = 3'd4
  } route_e;

  // dim 0: row crossbar, dim 1: column crossbar
  function automatic logic in_dim(input logic [2:0] r, input logic dim);
    return (r[2] == 1'b0) && (r[1] == dim);
  endfunction

endpackage

// File: rtl/roco_rr_arb.sv
module roco_rr_arb #(
  parameter  int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] win_idx;
  logic          any;

  always_comb begin
    int c;
    gnt_o   = '0;
    win_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      c = (int'(ptr_q) + k) % int'(N);
      if (!any && req_i[c]) begin
        any      = 1'b1;
        gnt_o[c] = 1'b1;
        win_idx  = IW'(c);
      end
    end
  end

  // pointer moves past the winner only when the grant is used
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (adv_i && any) begin
      ptr_q <= (win_idx == IW'(N - 1)) ? '0 : win_idx + 1'b1;
    end
  end

endmodule

// File: rtl/roco_port_sel.sv
module roco_port_sel
  import roco_alloc_pkg::*;
#(
  parameter int unsigned NUM_VC = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_VC-1:0]                  req_i,
  input  logic [NUM_VC-1:0][2:0]             route_i,
  input  logic [NUM_DIMS-1:0]                dim_won_i,
  output logic [NUM_DIMS-1:0]                cand_vld_o,
  output logic [NUM_DIMS-1:0]                cand_out_o,
  output logic [NUM_DIMS-1:0][NUM_VC-1:0]    cand_vc_o,
  output logic [NUM_VC-1:0]                  eject_gnt_o
);

  logic [NUM_VC-1:0]               ej_req;
  logic [NUM_DIMS-1:0][NUM_VC-1:0] dim_req;

  always_comb begin
    for (int v = 0; v < int'(NUM_VC); v++) begin
      ej_req[v] = req_i[v] && (route_i[v] == RT_EJECT);
      for (int d = 0; d < int'(NUM_DIMS); d++) begin
        dim_req[d][v] = req_i[v] && in_dim(route_i[v], 1'(d));
      end
    end
  end

  roco_rr_arb #(.N(NUM_VC)) u_ej_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (ej_req),
    .adv_i  (1'b1),
    .gnt_o  (eject_gnt_o)
  );

  for (genvar d = 0; d < NUM_DIMS; d++) begin : g_dim
    roco_rr_arb #(.N(NUM_VC)) u_vc_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (dim_req[d]),
      .adv_i  (dim_won_i[d]),
      .gnt_o  (cand_vc_o[d])
    );

    always_comb begin
      cand_out_o[d] = 1'b0;
      for (int v = 0; v < int'(NUM_VC); v++) begin
        if (cand_vc_o[d][v]) cand_out_o[d] = route_i[v][0];
      end
    end

    assign cand_vld_o[d] = |cand_vc_o[d];
  end

endmodule

// File: rtl/roco_xbar_alloc.sv
module roco_xbar_alloc (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cand_vld_i,
  input  logic [1:0] cand_out_i,
  output logic [1:0] port_won_o,
  output logic [1:0] out_vld_o,
  output logic [1:0] out_src_o
);

  logic [1:0] gnt;
  logic       w;
  logic       o;

  roco_rr_arb #(.N(2)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (cand_vld_i),
    .adv_i  (1'b1),
    .gnt_o  (gnt)
  );

  // one decision, mirrored onto the complementary output
  always_comb begin
    w          = gnt[1];
    o          = ~w;
    port_won_o = '0;
    out_vld_o  = '0;
    out_src_o  = '0;
    if (|gnt) begin
      port_won_o[w]             = 1'b1;
      out_vld_o[cand_out_i[w]]  = 1'b1;
      out_src_o[cand_out_i[w]]  = w;
      if (cand_vld_i[o] && (cand_out_i[o] != cand_out_i[w])) begin
        port_won_o[o]            = 1'b1;
        out_vld_o[cand_out_i[o]] = 1'b1;
        out_src_o[cand_out_i[o]] = o;
      end
    end
  end

endmodule

// File: rtl/roco_sw_alloc.sv
module roco_sw_alloc
  import roco_alloc_pkg::*;
#(
  parameter int unsigned NUM_VC = 4
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [NUM_PORTS-1:0][NUM_VC-1:0]       vc_req_i,
  input  logic [NUM_PORTS-1:0][NUM_VC-1:0][2:0]  vc_route_i,
  output logic [NUM_PORTS-1:0][NUM_VC-1:0]       eject_gnt_o,
  output logic [NUM_PORTS-1:0][NUM_VC-1:0]       sa_gnt_o,
  output logic [NUM_OUTS-1:0]                    xbar_vld_o,
  output logic [NUM_OUTS-1:0]                    xbar_src_o
);

  logic [NUM_PORTS-1:0][NUM_DIMS-1:0]             cand_vld;
  logic [NUM_PORTS-1:0][NUM_DIMS-1:0]             cand_out;
  logic [NUM_PORTS-1:0][NUM_DIMS-1:0][NUM_VC-1:0] cand_vc;
  logic [NUM_PORTS-1:0][NUM_DIMS-1:0]             won;

  logic [NUM_DIMS-1:0][NUM_PORTS-1:0] dm_vld;
  logic [NUM_DIMS-1:0][NUM_PORTS-1:0] dm_out;
  logic [NUM_DIMS-1:0][NUM_PORTS-1:0] dm_won;
  logic [NUM_DIMS-1:0][1:0]           dm_ovld;
  logic [NUM_DIMS-1:0][1:0]           dm_osrc;

  logic [NUM_PORTS-1:0][NUM_VC-1:0] sa_d;
  logic [NUM_OUTS-1:0]              vld_d, src_d;
  logic [NUM_OUTS-1:0]              vld_s1, src_s1;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    roco_port_sel #(.NUM_VC(NUM_VC)) u_sel (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (vc_req_i[p]),
      .route_i     (vc_route_i[p]),
      .dim_won_i   (won[p]),
      .cand_vld_o  (cand_vld[p]),
      .cand_out_o  (cand_out[p]),
      .cand_vc_o   (cand_vc[p]),
      .eject_gnt_o (eject_gnt_o[p])
    );
  end

  always_comb begin
    for (int p = 0; p < int'(NUM_PORTS); p++) begin
      for (int d = 0; d < int'(NUM_DIMS); d++) begin
        dm_vld[d][p] = cand_vld[p][d];
        dm_out[d][p] = cand_out[p][d];
      end
    end
  end

  for (genvar d = 0; d < NUM_DIMS; d++) begin : g_xbar
    roco_xbar_alloc u_xb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cand_vld_i (dm_vld[d]),
      .cand_out_i (dm_out[d]),
      .port_won_o (dm_won[d]),
      .out_vld_o  (dm_ovld[d]),
      .out_src_o  (dm_osrc[d])
    );
  end

  always_comb begin
    sa_d  = '0;
    vld_d = '0;
    src_d = '0;
    for (int p = 0; p < int'(NUM_PORTS); p++) begin
      for (int d = 0; d < int'(NUM_DIMS); d++) begin
        won[p][d] = dm_won[d][p];
        if (dm_won[d][p]) sa_d[p] = sa_d[p] | cand_vc[p][d];
      end
    end
    for (int d = 0; d < int'(NUM_DIMS); d++) begin
      for (int k = 0; k < 2; k++) begin
        vld_d[2*d+k] = dm_ovld[d][k];
        src_d[2*d+k] = dm_osrc[d][k];
      end
    end
  end

  // SA result registered, crossbar setting one stage later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sa_gnt_o   <= '0;
      vld_s1     <= '0;
      src_s1     <= '0;
      xbar_vld_o <= '0;
      xbar_src_o <= '0;
    end else begin
      sa_gnt_o   <= sa_d;
      vld_s1     <= vld_d;
      src_s1     <= src_d;
      xbar_vld_o <= vld_s1;
      xbar_src_o <= src_s1;
    end
  end

endmodule

// File: rtl/roco_sw_alloc_chk.sv
module roco_sw_alloc_chk
  import roco_alloc_pkg::*;
#(
  parameter int unsigned NUM_VC = 4
) (
  input logic                                  clk_i,
  input logic                                  rst_ni,
  input logic [NUM_PORTS-1:0][NUM_VC-1:0]      vc_req_i,
  input logic [NUM_PORTS-1:0][NUM_VC-1:0][2:0] vc_route_i,
  input logic [NUM_PORTS-1:0][NUM_VC-1:0]      eject_gnt_o,
  input logic [NUM_PORTS-1:0][NUM_VC-1:0]      sa_gnt_o,
  input logic [NUM_OUTS-1:0]                   xbar_vld_o,
  input logic [NUM_OUTS-1:0]                   xbar_src_o
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    // R3
    eject_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(eject_gnt_o[p]));
    // R7
    port_two_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(sa_gnt_o[p]) <= 2);
    for (genvar v = 0; v < NUM_VC; v++) begin : g_v
      // R3
      eject_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eject_gnt_o[p][v] |-> (vc_req_i[p][v] && vc_route_i[p][v] == 3'd4));
      // R8
      sa_from_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sa_gnt_o[p][v] |-> ($past(vc_req_i[p][v]) && !$past(vc_route_i[p][v][2])));
      // R10
      eject_no_sa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eject_gnt_o[p][v] |=> !sa_gnt_o[p][v]);
    end
  end

  for (genvar o = 0; o < NUM_OUTS; o++) begin : g_o
    // R9
    sel_after_sa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xbar_vld_o[o] |-> (xbar_src_o[o] ? $past(|sa_gnt_o[1]) : $past(|sa_gnt_o[0])));
  end

  for (genvar d = 0; d < NUM_DIMS; d++) begin : g_d
    // R7
    mirror_distinct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (xbar_vld_o[2*d] && xbar_vld_o[2*d+1]) |-> (xbar_src_o[2*d] != xbar_src_o[2*d+1]));
  end

endmodule

bind roco_sw_alloc roco_sw_alloc_chk #(.NUM_VC(NUM_VC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vc_req_i    (vc_req_i),
  .vc_route_i  (vc_route_i),
  .eject_gnt_o (eject_gnt_o),
  .sa_gnt_o    (sa_gnt_o),
  .xbar_vld_o  (xbar_vld_o),
  .xbar_src_o  (xbar_src_o)
);

// File: tb/roco_sw_alloc_tb_top.sv
module roco_sw_alloc_tb_top;

  localparam int NV = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0][NV-1:0]      vc_req_i = '0;
  logic [1:0][NV-1:0][2:0] vc_route_i = '0;
  logic [1:0][NV-1:0]      eject_gnt_o, sa_gnt_o;
  logic [3:0]              xbar_vld_o, xbar_src_o;

  always #4 clk_i = ~clk_i;

  roco_sw_alloc #(.NUM_VC(NV)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vc_req_i    (vc_req_i),
    .vc_route_i  (vc_route_i),
    .eject_gnt_o (eject_gnt_o),
    .sa_gnt_o    (sa_gnt_o),
    .xbar_vld_o  (xbar_vld_o),
    .xbar_src_o  (xbar_src_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  int ptr_ej[2];
  int ptr_vc[2][2];
  int ptr_xb[2];
  logic [1:0][NV-1:0] m_sa_prev;
  logic [3:0] m_vld_p1, m_vld_p2, m_src_p1, m_src_p2;

  logic [1:0][NV-1:0]      s_rq;
  logic [1:0][NV-1:0][2:0] s_rt;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      ptr_ej[i] = 0;
      ptr_xb[i] = 0;
      ptr_vc[i][0] = 0;
      ptr_vc[i][1] = 0;
    end
    m_sa_prev = '0;
    m_vld_p1 = '0; m_vld_p2 = '0;
    m_src_p1 = '0; m_src_p2 = '0;
  endtask

  task automatic model(output logic [1:0][NV-1:0] ej, output logic [1:0][NV-1:0] sa,
                       output logic [3:0] vld, output logic [3:0] src);
    bit cv[2][2];
    int cvc[2][2];
    int co[2][2];
    int c, w, o;
    ej = '0; sa = '0; vld = '0; src = '0;
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < NV; k++) begin
        c = (ptr_ej[p] + k) % NV;
        if (vc_req_i[p][c] && vc_route_i[p][c] == 3'd4) begin
          ej[p][c] = 1'b1;
          ptr_ej[p] = (c + 1) % NV;
          break;
        end
      end
      for (int d = 0; d < 2; d++) begin
        cv[d][p] = 0; cvc[d][p] = 0; co[d][p] = 0;
        for (int k = 0; k < NV; k++) begin
          c = (ptr_vc[p][d] + k) % NV;
          if (vc_req_i[p][c] && vc_route_i[p][c] < 3'd4 && int'(vc_route_i[p][c][1]) == d) begin
            cv[d][p] = 1; cvc[d][p] = c; co[d][p] = int'(vc_route_i[p][c][0]);
            break;
          end
        end
      end
    end
    for (int d = 0; d < 2; d++) begin
      if (cv[d][0] || cv[d][1]) begin
        w = cv[d][ptr_xb[d]] ? ptr_xb[d] : 1 - ptr_xb[d];
        o = 1 - w;
        sa[w][cvc[d][w]] = 1'b1;
        vld[2*d + co[d][w]] = 1'b1;
        src[2*d + co[d][w]] = 1'(w);
        ptr_vc[w][d] = (cvc[d][w] + 1) % NV;
        if (cv[d][o] && co[d][o] != co[d][w]) begin
          sa[o][cvc[d][o]] = 1'b1;
          vld[2*d + co[d][o]] = 1'b1;
          src[2*d + co[d][o]] = 1'(o);
          ptr_vc[o][d] = (cvc[d][o] + 1) % NV;
        end
        ptr_xb[d] = o;
      end
    end
  endtask

  task automatic step(input logic [1:0][NV-1:0] rq, input logic [1:0][NV-1:0][2:0] rt);
    logic [1:0][NV-1:0] ej, sa;
    logic [3:0] vld, src;
    @(negedge clk_i);
    vc_req_i = rq;
    vc_route_i = rt;
    #3;
    model(ej, sa, vld, src);
    chk("R3 eject_gnt", 32'(eject_gnt_o), 32'(ej));
    chk("R8 sa_gnt", 32'(sa_gnt_o), 32'(m_sa_prev));
    chk("R9 xbar_vld", 32'(xbar_vld_o), 32'(m_vld_p2));
    chk("R9 xbar_src", 32'(xbar_src_o & m_vld_p2), 32'(m_src_p2 & m_vld_p2));
    m_sa_prev = sa;
    m_vld_p2 = m_vld_p1; m_src_p2 = m_src_p1;
    m_vld_p1 = vld;      m_src_p1 = src;
  endtask

  task automatic idle();
    step('0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    vc_req_i = '0;
    vc_route_i = '0;
    repeat (2) @(negedge clk_i);
    model_reset();
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1 values held in reset
    chk("R1 sa_gnt in reset", 32'(sa_gnt_o), 0);
    chk("R1 xbar_vld in reset", 32'(xbar_vld_o), 0);
    chk("R1 xbar_src in reset", 32'(xbar_src_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R6: both want east, port 0 wins, west idle; R8/R9 latency
    do_reset();
    s_rq = '0; s_rt = '0;
    s_rq[0][0] = 1'b1; s_rt[0][0] = 3'd0;
    s_rq[1][0] = 1'b1; s_rt[1][0] = 3'd0;
    step(s_rq, s_rt);
    chk("R8 sa_gnt not early", 32'(sa_gnt_o), 0);
    idle();
    chk("R8 sa_gnt one cycle", 32'(sa_gnt_o), 32'h01);
    chk("R9 xbar not before two cycles", 32'(xbar_vld_o), 0);
    idle();
    chk("R6 west idle when mirror mismatched", 32'(xbar_vld_o), 32'b0001);
    chk("R9 east source port 0", 32'(xbar_src_o), 32'b0000);

    // R6: complementary requests use both row outputs
    do_reset();
    s_rq = '0; s_rt = '0;
    s_rq[0][1] = 1'b1; s_rt[0][1] = 3'd0;
    s_rq[1][2] = 1'b1; s_rt[1][2] = 3'd1;
    step(s_rq, s_rt);
    idle();
    chk("R6 both ports granted", 32'(sa_gnt_o), 32'h42);
    idle();
    chk("R6 east and west active", 32'(xbar_vld_o), 32'b0011);
    chk("R6 west sourced by port 1", 32'(xbar_src_o), 32'b0010);

    // R7: one port wins a row and a column output together
    do_reset();
    s_rq = '0; s_rt = '0;
    s_rq[0][0] = 1'b1; s_rt[0][0] = 3'd0;
    s_rq[0][1] = 1'b1; s_rt[0][1] = 3'd2;
    step(s_rq, s_rt);
    idle();
    chk("R7 two winners on one port", 32'(sa_gnt_o), 32'h03);
    idle();
    chk("R7 east and north active", 32'(xbar_vld_o), 32'b0101);

    // R3/R10: ejection in the request cycle, no crossbar use
    do_reset();
    s_rq = '0; s_rt = '0;
    s_rq[0][2] = 1'b1; s_rt[0][2] = 3'd4;
    s_rq[1][3] = 1'b1; s_rt[1][3] = 3'd4;
    step(s_rq, s_rt);
    chk("R3 same-cycle eject", 32'(eject_gnt_o), 32'h84);
    idle();
    chk("R10 eject takes no sa grant", 32'(sa_gnt_o), 0);
    idle();
    chk("R10 eject takes no crossbar output", 32'(xbar_vld_o), 0);

    // R4: VC round-robin inside a port
    do_reset();
    s_rq = '0; s_rt = '0;
    s_rq[0][0] = 1'b1; s_rt[0][0] = 3'd0;
    s_rq[0][1] = 1'b1; s_rt[0][1] = 3'd0;
    step(s_rq, s_rt);
    step(s_rq, s_rt);
    chk("R4 first grant vc0", 32'(sa_gnt_o), 32'h01);
    idle();
    chk("R4 second grant vc1", 32'(sa_gnt_o), 32'h02);

    // R5: port round-robin on one crossbar
    do_reset();
    s_rq = '0; s_rt = '0;
    s_rq[0][0] = 1'b1; s_rt[0][0] = 3'd3;
    s_rq[1][0] = 1'b1; s_rt[1][0] = 3'd3;
    step(s_rq, s_rt);
    step(s_rq, s_rt);
    chk("R5 port 0 first", 32'(sa_gnt_o), 32'h01);
    idle();
    chk("R5 port 1 next", 32'(sa_gnt_o), 32'h10);

    // R2: codes 5..7 ignored
    do_reset();
    s_rq = '1;
    for (int p = 0; p < 2; p++)
      for (int v = 0; v < NV; v++) s_rt[p][v] = 3'(5 + (v % 3));
    step(s_rq, s_rt);
    chk("R2 invalid route no eject", 32'(eject_gnt_o), 0);
    idle();
    chk("R2 invalid route no sa", 32'(sa_gnt_o), 0);
    idle();
    chk("R2 invalid route no crossbar", 32'(xbar_vld_o), 0);

    // mixed traffic against the reference model
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < 2; p++)
        for (int v = 0; v < NV; v++) begin
          s_rq[p][v] = ($urandom_range(0, 3) != 0);
          s_rt[p][v] = 3'($urandom_range(0, 7));
        end
      step(s_rq, s_rt);
    end
    idle();
    idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule